// File: doc/BRIEF.md
# Split-Access Bridge for 64-bit Control Registers

This block lets a bus that carries only 32-bit words reach a bank of 64-bit control registers. Each 64-bit register shows up as two adjacent 32-bit words: address bit 2 picks the half. A single 32-bit holding latch sits between the two halves, and reads and writes share it.

A write to the low half only parks the word in the latch. A write to the high half joins the incoming word (upper) with the latch (lower) and sends one 64-bit write strobe to the bank. A read of the low half returns the low word of the addressed register at once and moves its upper word into the latch. A later read of the high half returns the latch and does not touch the bank. The latch is shared, so a low-half read placed between the two halves of a write replaces the staged word. The block reproduces this on purpose.

The request side uses a valid/ready handshake and allows only one access in flight. The response comes back as a one-cycle pulse on the cycle after acceptance.

Top module: `csr_split_bridge`

## Requirements
- R1: After reset, rsp_valid and bank_wr_en are 0, req_ready is 1 and the holding latch is 0, so a high-half read as the first access returns 0.
- R2: Address bit 2 selects the half: 0 is the low word (bits 31:0 of the register) and 1 is the high word (bits 63:32).
- R3: An accepted low-half write loads req_wdata into the latch, produces no bank write, and responds with rsp_err = 0. This holds whether or not the offset is mapped.
- R4: An accepted high-half write to a mapped offset pulses bank_wr_en for one cycle, on the cycle after acceptance. bank_waddr is the request address with bit 2 cleared, and bank_wdata is {req_wdata, latch}.
- R5: An accepted low-half read to a mapped offset asserts bank_rd_en in the acceptance cycle, with bank_raddr equal to the address with bit 2 cleared. It returns bank_rdata[31:0] and loads the latch with bank_rdata[63:32].
- R6: An accepted high-half read keeps bank_rd_en at 0, returns the latch contents, and reports rsp_err = 0.
- R7: A low-half read to an unmapped offset returns 32'hFFFF_FFFF with rsp_err = 1 and leaves the latch unchanged.
- R8: A high-half write to an unmapped offset responds with rsp_err = 1 and produces no bank write.
- R9: Because reads and writes share the latch, a mapped low-half read between a low-half write and its high-half write makes the committed lower word equal to the upper word that was read.
- R10: An access is accepted when req_valid and req_ready are both 1. rsp_valid pulses for exactly the following cycle, and req_ready is 0 in that cycle.
- R11: An offset is mapped when its register index addr[AW-1:STRIDE_LOG2] is below NUM_REGS and bits [STRIDE_LOG2-1:3] and [1:0] are all zero. With the defaults, registers sit at multiples of 0x40 from 0x000 to 0x1C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Bridge can accept an access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte offset of the 32-bit half |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read word (0 for writes) |
| rsp_err | output | 1 | Unmapped low read or unmapped high write |
| bank_wr_en | output | 1 | 64-bit write strobe to the register bank |
| bank_waddr | output | AW | Write address, bit 2 cleared |
| bank_wdata | output | 64 | Joined 64-bit write value |
| bank_rd_en | output | 1 | Live bank read in this cycle |
| bank_raddr | output | AW | Read address, bit 2 cleared |
| bank_rdata | input | 64 | Combinational read data from the bank |

## Verification
The assertions assume the bank returns bank_rdata combinationally in the same cycle as bank_raddr. They also assume the requester keeps req_valid low, or simply waits, while req_ready is 0, so no access overlaps a pending response. The bench plays the register bank itself with a small array read through bank_raddr. It raises req_valid only after seeing req_ready high, and holds each request for exactly one accepting edge. Random addresses mix mapped registers, indices past the bank, and offsets with stray low bits set, so every decode path runs alongside the interleaving that corrupts the latch.

// File: rtl/csr_split_pkg.sv
package csr_split_pkg;
  localparam int WORD_W  = 32;
  localparam int DWORD_W = 64;

  typedef enum logic [1:0] {
    ACC_WR_LO = 2'd0,
    ACC_WR_HI = 2'd1,
    ACC_RD_LO = 2'd2,
    ACC_RD_HI = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic is_wr, input logic is_hi);
    return acc_kind_e'({~is_wr, is_hi});
  endfunction

  function automatic logic [DWORD_W-1:0] join_halves(input logic [WORD_W-1:0] hi,
                                                     input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] upper_word(input logic [DWORD_W-1:0] v);
    return v[DWORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] lower_word(input logic [DWORD_W-1:0] v);
    return v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int AW          = 12,
  parameter int NUM_REGS    = 8,
  parameter int STRIDE_LOG2 = 6
) (
  input  logic [AW-1:0] addr,
  output logic          half_hi,
  output logic          mapped,
  output logic [AW-1:0] base_addr
);
  localparam int IDX_W = AW - STRIDE_LOG2;

  logic [IDX_W-1:0] reg_idx;
  logic             pad_clear;
  logic             in_range;

  assign reg_idx   = addr[AW-1:STRIDE_LOG2];
  assign half_hi   = addr[2];
  assign pad_clear = (addr[STRIDE_LOG2-1:3] == '0) && (addr[1:0] == 2'b00);
  assign in_range  = ({{(32-IDX_W){1'b0}}, reg_idx} < 32'(NUM_REGS));
  assign mapped    = pad_clear && in_range;
  assign base_addr = {addr[AW-1:3], 1'b0, addr[1:0]};
endmodule

// File: rtl/csr_hold_latch.sv
module csr_hold_latch
  import csr_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_from_wr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              ld_from_rd,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld_from_wr) begin
      q <= wr_word;
    end else if (ld_from_rd) begin
      q <= rd_word;
    end
  end
endmodule

// File: rtl/csr_commit_stage.sv
module csr_commit_stage
  import csr_split_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [AW-1:0]      addr_in,
  input  logic [DWORD_W-1:0] data_in,
  output logic               wr_en,
  output logic [AW-1:0]      waddr,
  output logic [DWORD_W-1:0] wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        waddr <= addr_in;
        wdata <= data_in;
      end
    end
  end
endmodule

// File: rtl/csr_split_bridge.sv
module csr_split_bridge
  import csr_split_pkg::*;
#(
  parameter int AW          = 12,
  parameter int NUM_REGS    = 8,
  parameter int STRIDE_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               bank_wr_en,
  output logic [AW-1:0]      bank_waddr,
  output logic [63:0]        bank_wdata,
  output logic               bank_rd_en,
  output logic [AW-1:0]      bank_raddr,
  input  logic [63:0]        bank_rdata
);
  logic            half_hi;
  logic            acc_mapped;
  logic [AW-1:0]   base_addr;
  logic            acc;
  acc_kind_e       kind;
  logic [WORD_W-1:0] latch_q;

  // named events, shared with the checker
  logic ev_stage, ev_commit, ev_drop, ev_rd_live, ev_rd_bad, ev_rd_latch;

  csr_addr_decode #(
    .AW(AW), .NUM_REGS(NUM_REGS), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_dec (
    .addr(req_addr), .half_hi(half_hi), .mapped(acc_mapped), .base_addr(base_addr)
  );

  assign acc  = req_valid && req_ready;
  assign kind = classify(req_write, half_hi);

  assign ev_stage    = acc && (kind == ACC_WR_LO);
  assign ev_commit   = acc && (kind == ACC_WR_HI) && acc_mapped;
  assign ev_drop     = acc && (kind == ACC_WR_HI) && !acc_mapped;
  assign ev_rd_live  = acc && (kind == ACC_RD_LO) && acc_mapped;
  assign ev_rd_bad   = acc && (kind == ACC_RD_LO) && !acc_mapped;
  assign ev_rd_latch = acc && (kind == ACC_RD_HI);

  assign bank_rd_en = ev_rd_live;
  assign bank_raddr = base_addr;

  csr_hold_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .ld_from_wr(ev_stage),   .wr_word(req_wdata),
    .ld_from_rd(ev_rd_live), .rd_word(upper_word(bank_rdata)),
    .q(latch_q)
  );

  csr_commit_stage #(.AW(AW)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .fire(ev_commit),
    .addr_in(base_addr),
    .data_in(join_halves(req_wdata, latch_q)),
    .wr_en(bank_wr_en), .waddr(bank_waddr), .wdata(bank_wdata)
  );

  logic [WORD_W-1:0] rdata_next;
  always_comb begin
    rdata_next = '0;
    if (ev_rd_live)       rdata_next = lower_word(bank_rdata);
    else if (ev_rd_bad)   rdata_next = '1;
    else if (ev_rd_latch) rdata_next = latch_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_err   <= ev_drop || ev_rd_bad;
      rsp_rdata <= rdata_next;
    end
  end

  assign req_ready = !rsp_valid;
endmodule

// File: rtl/csr_split_checker.sv
module csr_split_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_wdata,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata,
  input logic          rsp_err,
  input logic          bank_wr_en,
  input logic [AW-1:0] bank_waddr,
  input logic [63:0]   bank_wdata,
  input logic          bank_rd_en,
  input logic [63:0]   bank_rdata,
  input logic [31:0]   latch_q,
  input logic          ev_stage,
  input logic          ev_commit,
  input logic          ev_drop,
  input logic          ev_rd_live,
  input logic          ev_rd_bad,
  input logic          ev_rd_latch
);
  localparam logic [AW-1:0] HALF_BIT = AW'(4);

  p_stage_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stage |=> (!bank_wr_en && !rsp_err && latch_q == $past(req_wdata)));

  p_commit_join_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (bank_wr_en && bank_wdata == {$past(req_wdata), $past(latch_q)}
                   && bank_waddr == ($past(req_addr) & ~HALF_BIT)));

  p_live_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_live |=> (rsp_rdata == $past(bank_rdata[31:0])
                    && latch_q == $past(bank_rdata[63:32]) && !rsp_err));

  p_latch_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_latch |=> (rsp_rdata == $past(latch_q) && !rsp_err));

  p_latch_no_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_latch |-> !bank_rd_en);

  p_bad_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_bad |=> (rsp_err && rsp_rdata == 32'hFFFF_FFFF && $stable(latch_q)));

  p_drop_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (rsp_err && !bank_wr_en));

  p_resp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |=> !bank_wr_en);

  p_events_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_stage, ev_commit, ev_drop, ev_rd_live, ev_rd_bad, ev_rd_latch}));
endmodule

bind csr_split_bridge csr_split_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .bank_wr_en(bank_wr_en), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata),
  .bank_rd_en(bank_rd_en), .bank_rdata(bank_rdata),
  .latch_q(latch_q),
  .ev_stage(ev_stage), .ev_commit(ev_commit), .ev_drop(ev_drop),
  .ev_rd_live(ev_rd_live), .ev_rd_bad(ev_rd_bad), .ev_rd_latch(ev_rd_latch)
);

// File: tb/sim_csr_split_bridge.sv
`timescale 1ns/1ps
module sim_csr_split_bridge;
  localparam int AW = 12;
  localparam int NREG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic          bank_wr_en;
  logic [AW-1:0] bank_waddr;
  logic [63:0]   bank_wdata;
  logic          bank_rd_en;
  logic [AW-1:0] bank_raddr;
  logic [63:0]   bank_rdata;

  always #4 clk = ~clk;

  csr_split_bridge #(.AW(AW), .NUM_REGS(NREG), .STRIDE_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bank_wr_en(bank_wr_en), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata),
    .bank_rd_en(bank_rd_en), .bank_raddr(bank_raddr), .bank_rdata(bank_rdata)
  );

  // the bench acts as the register bank
  logic [63:0] bank_mem [NREG];
  assign bank_rdata = bank_mem[bank_raddr[8:6]];
  always @(posedge clk) if (bank_wr_en) bank_mem[bank_waddr[8:6]] <= bank_wdata;

  // reference model state
  logic [63:0] exp_mem [NREG];
  logic [31:0] exp_latch;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        got_ren, got_wen, got_err, got_rv, got_rdy;
  logic [AW-1:0] got_raddr, got_waddr;
  logic [31:0] got_rdata;
  logic [63:0] got_wdata;

  function automatic bit ref_mapped(input logic [AW-1:0] a);
    return (a[AW-1:6] < NREG) && ((a & 12'h03B) == 12'h000);
  endfunction

  function automatic logic [AW-1:0] ref_base(input logic [AW-1:0] a);
    return a & ~12'h004;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    check(req_ready === 1'b1, "R10 ready idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    got_ren = bank_rd_en; got_raddr = bank_raddr;
    @(negedge clk);
    req_valid = 1'b0;
    got_rv = rsp_valid; got_rdy = req_ready; got_err = rsp_err; got_rdata = rsp_rdata;
    got_wen = bank_wr_en; got_waddr = bank_waddr; got_wdata = bank_wdata;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    logic [63:0] joined;
    int idx;
    idx = int'(a[8:6]);
    issue(wr, a, d);
    check(got_rv === 1'b1 && got_rdy === 1'b0, "R10 response pulse",
          {62'd0, got_rv, got_rdy}, 64'd2);
    if (wr && !a[2]) begin
      check(got_wen === 1'b0 && got_err === 1'b0, "R3 low write staged only",
            {62'd0, got_wen, got_err}, 64'd0);
      exp_latch = d;
    end else if (wr && a[2]) begin
      if (ref_mapped(a)) begin
        joined = {d, exp_latch};
        check(got_wen === 1'b1 && got_err === 1'b0, "R4 commit strobe",
              {62'd0, got_wen, got_err}, 64'd2);
        check(got_wdata === joined, "R4 commit data", got_wdata, joined);
        check(got_waddr === ref_base(a), "R4 commit address", 64'(got_waddr), 64'(ref_base(a)));
        exp_mem[idx] = joined;
      end else begin
        check(got_wen === 1'b0 && got_err === 1'b1, "R8 unmapped high write",
              {62'd0, got_wen, got_err}, 64'd1);
      end
    end else if (!a[2]) begin
      if (ref_mapped(a)) begin
        check(got_ren === 1'b1 && got_raddr === ref_base(a), "R5 live read address",
              64'(got_raddr), 64'(ref_base(a)));
        check(got_rdata === exp_mem[idx][31:0] && got_err === 1'b0, "R5 low word",
              64'(got_rdata), 64'(exp_mem[idx][31:0]));
        exp_latch = exp_mem[idx][63:32];
      end else begin
        check(got_rdata === 32'hFFFF_FFFF && got_err === 1'b1, "R7 unmapped low read",
              {31'd0, got_err, got_rdata}, {31'd0, 1'b1, 32'hFFFF_FFFF});
      end
    end else begin
      check(got_ren === 1'b0, "R6 no bank access", 64'(got_ren), 64'd0);
      check(got_rdata === exp_latch && got_err === 1'b0, "R6 latch read",
            64'(got_rdata), 64'(exp_latch));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] seen;
    void'($urandom(32'd7717));
    for (int i = 0; i < NREG; i++) begin
      bank_mem[i] = {32'hC0DE_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
      exp_mem[i]  = {32'hC0DE_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
    end
    exp_latch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0 && bank_wr_en === 1'b0 && req_ready === 1'b1, "R1 reset state",
          {61'd0, rsp_valid, bank_wr_en, req_ready}, 64'd1);
    rst_n = 1'b1;

    // R1: first high read returns cleared latch
    access(1'b0, 12'h0C4, 32'h0);
    check(got_rdata === 32'h0, "R1 latch cleared", 64'(got_rdata), 64'd0);

    // R2/R3/R4: split write to register 3, little-endian halves
    access(1'b1, 12'h0C0, 32'hAAAA_5555);
    access(1'b1, 12'h0C4, 32'h0F0F_F0F0);
    access(1'b0, 12'h0C0, 32'h0);
    check(got_rdata === 32'hAAAA_5555, "R2 low half is bits 31:0", 64'(got_rdata), 64'hAAAA_5555);
    access(1'b0, 12'h0C4, 32'h0);
    check(got_rdata === 32'h0F0F_F0F0, "R2 high half is bits 63:32", 64'(got_rdata), 64'h0F0F_F0F0);

    // R7: unmapped low read keeps latch
    access(1'b0, 12'h240, 32'h0);
    access(1'b0, 12'h1C4, 32'h0);
    check(got_rdata === 32'h0F0F_F0F0, "R7 latch unchanged", 64'(got_rdata), 64'h0F0F_F0F0);

    // R8 and R11: unmapped high writes (index past bank, stray pad bit)
    access(1'b1, 12'h200, 32'h1111_1111);
    access(1'b1, 12'h204, 32'h2222_2222);
    access(1'b1, 12'h04C, 32'h3333_3333);
    check(got_err === 1'b1, "R11 pad bits unmapped", 64'(got_err), 64'd1);
    access(1'b0, 12'h041, 32'h0);
    check(got_err === 1'b1, "R11 low byte bits unmapped", 64'(got_err), 64'd1);
    access(1'b0, 12'h1C0, 32'h0);
    check(got_err === 1'b0, "R11 last register mapped", 64'(got_err), 64'd0);

    // R9: read between halves of a write replaces the staged word
    access(1'b1, 12'h140, 32'hDEAD_BEEF);
    access(1'b0, 12'h040, 32'h0);
    access(1'b1, 12'h144, 32'h7777_0000);
    seen = got_wdata;
    check(seen[31:0] === exp_mem[1][63:32] && seen[31:0] !== 32'hDEAD_BEEF,
          "R9 shared latch corrupts staged word", 64'(seen[31:0]), 64'(exp_mem[1][63:32]));

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      logic [31:0] r;
      r = $urandom;
      a = {r[3:0] % 4'd10, 6'd0} | {9'd0, r[4], 2'd0};
      if (r[7:5] == 3'd0) a = a | 12'h010;
      if (r[10:8] == 3'd1) a = a | 12'h002;
      access(r[11], a, $urandom);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule